// File: doc/BRIEF.md
# Fast Page Mode DRAM Sequencer

This block sits between a host and one 16-bit dynamic RAM that takes its address in two halves over a 9-bit bus. The host hands it one request at a time: read or write, an 18-bit word address and a 2-bit byte enable. The upper nine address bits become the row and the lower nine become the column. The block drives the row strobe, the two byte-lane column strobes, the write and output enables, the multiplexed address and the direction of the data bus. For reads it returns the captured word with a one-cycle valid pulse.

After an access the row is left open. A later request to the same row then needs only a column cycle. The row is closed in three cases: a request names another row, an outside refresh engine asks for the bus, or the row has been open long enough that it must be shut before the maximum row-active time. Every delay is a whole number of clock cycles set by a parameter. The derived widths (column pulse, row-active minimum, column precharge) are computed from those parameters when the block is built.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, the row strobe, both column strobes, the write enable and the output enable are high. Data-bus drive, read-valid, refresh grant and request-ready are all low.
- R2: The row address, reqAddr[17:9], is on dramAddr in the cycle in which dramRasN first goes low. The column address, reqAddr[8:0], is on dramAddr in the cycle in which a column strobe first goes low. A column strobe is only ever low while dramRasN is low.
- R3: Byte enable bit 0 lowers dramLcasN, which covers data bits 7:0. Bit 1 lowers dramUcasN, which covers bits 15:8. A lane whose enable bit is 0 keeps its strobe high for the whole access, so a byte write leaves the other byte of the stored word unchanged.
- R4: A write is an early write. dramWeN is low and dramDqOe is high before the column strobe falls. Both stay that way for as long as the strobe is low, and dramOeN stays high throughout.
- R5: A read holds dramWeN high and dramOeN low, with dramDqOe low, for as long as the column strobe is low. The word on dramDqIn in the last strobe-low cycle appears on rdData with rdValid high for exactly one cycle.
- R6: A request to the row already open is served by a column cycle alone. dramRasN does not rise.
- R7: A request to a different row closes the open row. dramRasN then stays high for at least T_RP cycles before it falls again.
- R8: dramRasN stays low for at least max(T_RAS, T_RC−T_RP) cycles. The delay from dramRasN falling to the column strobe falling is exactly T_RCD+1 cycles. A column strobe stays low for at least max(T_CAS, T_AA, T_RAC−T_RCD−1) cycles. Between column cycles in one row, the strobes stay high for at least one cycle.
- R9: dramRasN never stays low for more than PAGE_LIMIT consecutive cycles, even when same-row requests keep arriving.
- R10: A refresh request closes any open row. refGnt rises only after dramRasN has been high for at least T_RP cycles. While refGnt is high, no request is accepted. When refReq drops, the grant is released and T_RP more cycles pass before the next row opens.
- R11: A request is taken in the cycle where reqValid and reqReady are both high. Each read taken yields exactly one rdValid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address: row in [17:9], column in [8:0] |
| reqByteEn | input | 2 | Byte lanes: bit 0 = data[7:0], bit 1 = data[15:8] |
| reqWdata | input | 16 | Write data |
| reqReady | output | 1 | Request accepted this cycle if reqValid is high |
| rdData | output | 16 | Captured read word |
| rdValid | output | 1 | One-cycle pulse when rdData is new |
| refReq | input | 1 | Outside refresh engine asks for the memory |
| refGnt | output | 1 | Memory is idle and precharged; the refresh engine may use it |
| dramRasN | output | 1 | Row strobe, active low |
| dramLcasN | output | 1 | Lower byte column strobe, active low |
| dramUcasN | output | 1 | Upper byte column strobe, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramOeN | output | 1 | Output enable, active low |
| dramAddr | output | 9 | Multiplexed row/column address |
| dramDqOut | output | 16 | Data to memory |
| dramDqOe | output | 1 | Drive dramDqOut onto the data bus |
| dramDqIn | input | 16 | Data from memory |

## Verification
The pin-level assertions rely on reqAddr, reqWrite and reqByteEn staying stable while reqValid waits for reqReady. They also rely on refReq staying high until refGnt has been seen. The row-active limit assumes PAGE_LIMIT is larger than the column cycle plus the minimum row-active time, and an elaboration check enforces this. The stimulus holds each request unchanged from the falling edge of the clock until the rising edge on which it is accepted. It raises refresh only between requests and keeps it high until the grant. The memory model behind the pins answers combinationally from the latched row and the present column.

// File: rtl/fpm_dram_pkg.sv
package fpm_dram_pkg;

  localparam int AW = 9;
  localparam int DW = 16;

  typedef enum logic [2:0] {
    S_PRE, S_IDLE, S_RCD, S_COLSET, S_CAS, S_OPEN, S_REF
  } seqState_t;

  // Strobe bundle from the sequencer to the pin register stage.
  typedef struct packed {
    logic          rasN;
    logic          lcasN;
    logic          ucasN;
    logic          weN;
    logic          oeN;
    logic          dqOe;
    logic          capture;
    logic [AW-1:0] addr;
  } pinStb_t;

  localparam pinStb_t STB_IDLE = '{rasN: 1'b1, lcasN: 1'b1, ucasN: 1'b1,
                                   weN: 1'b1, oeN: 1'b1, dqOe: 1'b0,
                                   capture: 1'b0, addr: '0};

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Column strobe width: covers strobe access, column access, and row
  // access measured from the row strobe (row-to-column is tRcd+1 cycles).
  function automatic int casLowOf(input int tCas, input int tAa,
                                  input int tRac, input int tRcd);
    return maxOf(maxOf(tCas, tAa), maxOf(tRac - tRcd - 1, 1));
  endfunction

endpackage

// File: rtl/fpm_dram_control.sv
module fpm_dram_control
  import fpm_dram_pkg::*;
#(
  parameter int T_RP       = 4,
  parameter int T_RCD      = 2,
  parameter int T_RAS      = 6,
  parameter int T_RC       = 11,
  parameter int T_CAS      = 2,
  parameter int T_CP       = 1,
  parameter int T_PC       = 4,
  parameter int T_AA       = 3,
  parameter int T_RAC      = 6,
  parameter int PAGE_LIMIT = 10000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            reqWrite,
  input  logic [2*AW-1:0] reqAddr,
  input  logic [1:0]      reqByteEn,
  output logic            reqReady,
  input  logic            refReq,
  output logic            refGnt,
  output pinStb_t         stb
);

  localparam int CAS_LOW = casLowOf(T_CAS, T_AA, T_RAC, T_RCD);
  localparam int RAS_MIN = maxOf(T_RAS, T_RC - T_RP);
  localparam int CP_MIN  = maxOf(maxOf(T_CP, T_PC - CAS_LOW), 1);
  localparam int GUARD   = CAS_LOW + CP_MIN + 3;
  localparam int CNT_MAX = maxOf(maxOf(T_RP, T_RCD), maxOf(CAS_LOW, CP_MIN));
  localparam int CNT_W   = $clog2(CNT_MAX + 1) + 1;
  localparam int RAS_W   = $clog2(PAGE_LIMIT + 1) + 1;

  localparam logic [CNT_W-1:0] RP_LAST  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] RCD_LAST = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] CAS_LAST = CNT_W'(CAS_LOW - 1);
  localparam logic [CNT_W-1:0] CP_LAST  = CNT_W'(CP_MIN - 1);
  localparam logic [RAS_W-1:0] RMIN_LAST = RAS_W'(RAS_MIN - 1);
  localparam logic [RAS_W-1:0] NEAR_END  = RAS_W'(PAGE_LIMIT - GUARD);

  if (T_RCD < 1) begin : g_rcdCheck
    $error("T_RCD must be at least 1");
  end
  if (T_RP < 1) begin : g_rpCheck
    $error("T_RP must be at least 1");
  end
  if (PAGE_LIMIT <= GUARD + RAS_MIN) begin : g_limitCheck
    $error("PAGE_LIMIT too small for one column cycle");
  end

  seqState_t       state;
  logic [CNT_W-1:0] cnt;
  logic [RAS_W-1:0] rasCnt;
  logic [AW-1:0]    openRow;
  logic [AW-1:0]    curCol;
  logic             curWrite;
  logic [1:0]       curBe;

  logic rowHit, nearLimit, canClose, cpOk, closeWanted;

  assign rowHit      = (reqAddr[2*AW-1:AW] == openRow);
  assign nearLimit   = (rasCnt >= NEAR_END);
  assign canClose    = (rasCnt >= RMIN_LAST);
  assign cpOk        = (cnt >= CP_LAST);
  assign closeWanted = refReq || nearLimit || (reqValid && !rowHit);
  assign refGnt      = (state == S_REF);

  always_comb begin
    reqReady = 1'b0;
    unique case (state)
      S_IDLE:  reqReady = !refReq;
      S_OPEN:  reqReady = !refReq && rowHit && cpOk && !nearLimit;
      default: reqReady = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_PRE;
      cnt      <= '0;
      rasCnt   <= '0;
      openRow  <= '0;
      curCol   <= '0;
      curWrite <= 1'b0;
      curBe    <= '0;
    end else begin
      unique case (state)
        S_PRE: begin
          if (cnt == RP_LAST) begin
            cnt   <= '0;
            state <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_IDLE: begin
          if (refReq) begin
            state <= S_REF;
          end else if (reqValid) begin
            openRow  <= reqAddr[2*AW-1:AW];
            curCol   <= reqAddr[AW-1:0];
            curWrite <= reqWrite;
            curBe    <= reqByteEn;
            rasCnt   <= '0;
            cnt      <= '0;
            state    <= S_RCD;
          end
        end
        S_RCD: begin
          rasCnt <= rasCnt + 1'b1;
          if (cnt == RCD_LAST) begin
            cnt   <= '0;
            state <= S_COLSET;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_COLSET: begin
          rasCnt <= rasCnt + 1'b1;
          cnt    <= '0;
          state  <= S_CAS;
        end
        S_CAS: begin
          rasCnt <= rasCnt + 1'b1;
          if (cnt == CAS_LAST) begin
            cnt   <= '0;
            state <= S_OPEN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_OPEN: begin
          rasCnt <= rasCnt + 1'b1;
          if (reqValid && reqReady) begin
            curCol   <= reqAddr[AW-1:0];
            curWrite <= reqWrite;
            curBe    <= reqByteEn;
            cnt      <= '0;
            state    <= S_COLSET;
          end else if (closeWanted && canClose) begin
            cnt   <= '0;
            state <= S_PRE;
          end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_REF: begin
          if (!refReq) begin
            cnt   <= '0;
            state <= S_PRE;
          end
        end
        default: state <= S_PRE;
      endcase
    end
  end

  always_comb begin
    stb      = STB_IDLE;
    stb.addr = openRow;
    unique case (state)
      S_IDLE: stb.addr = reqAddr[2*AW-1:AW];
      S_RCD:  stb.rasN = 1'b0;
      S_COLSET: begin
        stb.rasN = 1'b0;
        stb.addr = curCol;
        stb.weN  = !curWrite;
        stb.dqOe = curWrite;
      end
      S_CAS: begin
        stb.rasN    = 1'b0;
        stb.addr    = curCol;
        stb.lcasN   = !curBe[0];
        stb.ucasN   = !curBe[1];
        stb.weN     = !curWrite;
        stb.oeN     = curWrite;
        stb.dqOe    = curWrite;
        stb.capture = !curWrite && (cnt == CAS_LAST);
      end
      S_OPEN: begin
        stb.rasN = 1'b0;
        stb.addr = curCol;
      end
      default: ;
    endcase
  end

  // R10: nothing is taken while the refresh engine owns the memory
  a_r10_no_accept_in_grant: assert property (@(posedge clk) disable iff (!rstN)
    refGnt |-> !reqReady);

  // R6: a same-row request goes straight to a column cycle on the held row
  a_r6_hit_keeps_row: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_OPEN && reqValid && reqReady)
      |=> (state == S_COLSET && openRow == $past(reqAddr[2*AW-1:AW])));

  // R9: the internal row-active count stays within the limit
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    rasCnt <= RAS_W'(PAGE_LIMIT));

endmodule

// File: rtl/fpm_dram_datapath.sv
module fpm_dram_datapath
  import fpm_dram_pkg::*;
#(
  parameter int CAS_LOW    = 3,
  parameter int T_RP       = 4,
  parameter int PAGE_LIMIT = 10000
) (
  input  logic          clk,
  input  logic          rstN,
  input  pinStb_t       stb,
  input  logic          wrLoad,
  input  logic [DW-1:0] wrData,
  input  logic [DW-1:0] dqIn,
  output logic          rasN,
  output logic          lcasN,
  output logic          ucasN,
  output logic          weN,
  output logic          oeN,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dqOut,
  output logic          dqOe,
  output logic [DW-1:0] rdData,
  output logic          rdValid
);

  pinStb_t       stbQ;
  logic [DW-1:0] wdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbQ    <= STB_IDLE;
      wdataQ  <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      stbQ    <= stb;
      rdValid <= stbQ.capture;
      if (wrLoad)       wdataQ <= wrData;
      if (stbQ.capture) rdData <= dqIn;
    end
  end

  assign rasN  = stbQ.rasN;
  assign lcasN = stbQ.lcasN;
  assign ucasN = stbQ.ucasN;
  assign weN   = stbQ.weN;
  assign oeN   = stbQ.oeN;
  assign addr  = stbQ.addr;
  assign dqOe  = stbQ.dqOe;
  assign dqOut = wdataQ;

  // Pin run-length counters used only by the assertions below.
  localparam int RW = $clog2(PAGE_LIMIT + 2) + 1;
  localparam int HW = $clog2(T_RP + 2) + 1;
  localparam int CW = $clog2(CAS_LOW + 2) + 1;

  logic          casHigh;
  logic [RW-1:0] rasLowRun;
  logic [HW-1:0] rasHighRun;
  logic [CW-1:0] casLowRun;

  assign casHigh = stbQ.lcasN & stbQ.ucasN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasLowRun  <= '0;
      rasHighRun <= '0;
      casLowRun  <= '0;
    end else begin
      if (!stbQ.rasN) begin
        rasHighRun <= '0;
        if (rasLowRun != '1) rasLowRun <= rasLowRun + 1'b1;
      end else begin
        rasLowRun <= '0;
        if (rasHighRun != '1) rasHighRun <= rasHighRun + 1'b1;
      end
      if (!casHigh) begin
        if (casLowRun != '1) casLowRun <= casLowRun + 1'b1;
      end else begin
        casLowRun <= '0;
      end
    end
  end

  a_r9_ras_limit: assert property (@(posedge clk) disable iff (!rstN)
    rasLowRun <= RW'(PAGE_LIMIT));

  a_r7_precharge: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> rasHighRun >= HW'(T_RP));

  a_r8_cas_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(casHigh) |-> casLowRun >= CW'(CAS_LOW));

  a_r2_cas_inside_ras: assert property (@(posedge clk) disable iff (!rstN)
    (!lcasN || !ucasN) |-> !rasN);

  a_r4_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> oeN);

  a_r4_we_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!casHigh && !$past(casHigh)) |-> $stable(weN));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_dram_pkg::*;
#(
  parameter int T_RP       = 4,
  parameter int T_RCD      = 2,
  parameter int T_RAS      = 6,
  parameter int T_RC       = 11,
  parameter int T_CAS      = 2,
  parameter int T_CP       = 1,
  parameter int T_PC       = 4,
  parameter int T_AA       = 3,
  parameter int T_RAC      = 6,
  parameter int PAGE_LIMIT = 10000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [17:0] reqAddr,
  input  logic [1:0]  reqByteEn,
  input  logic [15:0] reqWdata,
  output logic        reqReady,
  output logic [15:0] rdData,
  output logic        rdValid,
  input  logic        refReq,
  output logic        refGnt,
  output logic        dramRasN,
  output logic        dramLcasN,
  output logic        dramUcasN,
  output logic        dramWeN,
  output logic        dramOeN,
  output logic [8:0]  dramAddr,
  output logic [15:0] dramDqOut,
  output logic        dramDqOe,
  input  logic [15:0] dramDqIn
);

  localparam int CAS_LOW = casLowOf(T_CAS, T_AA, T_RAC, T_RCD);

  pinStb_t stb;

  fpm_dram_control #(
    .T_RP(T_RP), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC),
    .T_CAS(T_CAS), .T_CP(T_CP), .T_PC(T_PC), .T_AA(T_AA),
    .T_RAC(T_RAC), .PAGE_LIMIT(PAGE_LIMIT)
  ) u_control (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqByteEn(reqByteEn), .reqReady(reqReady),
    .refReq(refReq), .refGnt(refGnt), .stb(stb)
  );

  fpm_dram_datapath #(
    .CAS_LOW(CAS_LOW), .T_RP(T_RP), .PAGE_LIMIT(PAGE_LIMIT)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrLoad(reqValid && reqReady), .wrData(reqWdata), .dqIn(dramDqIn),
    .rasN(dramRasN), .lcasN(dramLcasN), .ucasN(dramUcasN),
    .weN(dramWeN), .oeN(dramOeN), .addr(dramAddr),
    .dqOut(dramDqOut), .dqOe(dramDqOe),
    .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: tb/tb_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module tb_fpm_dram_ctrl;

  localparam int T_RP = 4;
  localparam int T_RCD = 2;
  localparam int LIMIT = 60;
  localparam int CAS_MIN = 3;   // max(2, 3, 6-2-1)
  localparam int RAS_MIN = 7;   // max(6, 11-4)

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [1:0] reqByteEn = 2'b11;
  logic [15:0] reqWdata = '0;
  logic reqReady, rdValid, refGnt;
  logic [15:0] rdData;
  logic refReq = 1'b0;
  logic dramRasN, dramLcasN, dramUcasN, dramWeN, dramOeN, dramDqOe;
  logic [8:0] dramAddr;
  logic [15:0] dramDqOut, dramDqIn;

  always #5 clk = ~clk;

  fpm_dram_ctrl #(.PAGE_LIMIT(LIMIT)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqByteEn(reqByteEn), .reqWdata(reqWdata),
    .reqReady(reqReady), .rdData(rdData), .rdValid(rdValid),
    .refReq(refReq), .refGnt(refGnt), .dramRasN(dramRasN),
    .dramLcasN(dramLcasN), .dramUcasN(dramUcasN), .dramWeN(dramWeN),
    .dramOeN(dramOeN), .dramAddr(dramAddr), .dramDqOut(dramDqOut),
    .dramDqOe(dramDqOe), .dramDqIn(dramDqIn)
  );

  int nChecks = 0, nFails = 0;
  bit done = 0;

  task automatic check(input string req, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic checkTrue(input string req, input bit cond, input int got, input int bound);
    nChecks++;
    if (!cond) begin
      nFails++;
      $display("FAIL %s: got %0d against bound %0d", req, got, bound);
    end
  endtask

  function automatic logic [15:0] pat(input int idx);
    return 16'(idx * 16'h0101) ^ 16'h5a5a;
  endfunction

  function automatic logic [17:0] mk(input int row, input int col);
    return {9'(row), 9'(col)};
  endfunction

  // memory model behind the pins
  logic [15:0] mem [0:1023];
  logic [8:0]  rowL, colL;
  int rasFalls, lFalls, uFalls, rdPulses, modeErr;
  int rasLowRun, rasHighRun, casLowRun, casHighRun;
  int maxRasLow, minRasLow, minPre, minCasLow, minCasHigh, lastRcd;
  bit prevRas, prevCas, prevWe, firstCas;

  initial for (int i = 0; i < 1024; i++) mem[i] = pat(i);

  always_comb begin
    logic [15:0] w;
    w = mem[{rowL[4:0], dramAddr[4:0]}];
    dramDqIn = {(!dramUcasN) ? w[15:8] : 8'h00, (!dramLcasN) ? w[7:0] : 8'h00};
  end

  always @(negedge clk) begin
    if (!rstN) begin
      prevRas = 1; prevCas = 0; prevWe = 1; firstCas = 1;
      rasFalls = 0; lFalls = 0; uFalls = 0; rdPulses = 0; modeErr = 0;
      rasLowRun = 0; rasHighRun = 0; casLowRun = 0; casHighRun = 0;
      maxRasLow = 0; minRasLow = 1000; minPre = 1000; minCasLow = 1000;
      minCasHigh = 1000; lastRcd = -1; rowL = '0; colL = '0;
    end else begin
      bit casLo;
      casLo = !(dramLcasN & dramUcasN);
      if (!dramRasN) begin
        if (prevRas) begin
          rasFalls++; rowL = dramAddr; firstCas = 1;
          if (rasHighRun < minPre) minPre = rasHighRun;
          rasLowRun = 0;
        end
        rasLowRun++;
        if (rasLowRun > maxRasLow) maxRasLow = rasLowRun;
      end else begin
        if (!prevRas) begin
          if (rasLowRun < minRasLow) minRasLow = rasLowRun;
          rasHighRun = 0;
        end
        rasHighRun++;
      end
      if (casLo) begin
        if (!prevCas) begin
          colL = dramAddr;
          if (!dramLcasN) lFalls++;
          if (!dramUcasN) uFalls++;
          if (firstCas) lastRcd = rasLowRun - 1;
          else if (casHighRun < minCasHigh) minCasHigh = casHighRun;
          firstCas = 0;
          casLowRun = 0;
          if (!dramWeN) begin
            if (!dramDqOe) modeErr++;
            if (!dramLcasN) mem[{rowL[4:0], dramAddr[4:0]}][7:0] = dramDqOut[7:0];
            if (!dramUcasN) mem[{rowL[4:0], dramAddr[4:0]}][15:8] = dramDqOut[15:8];
          end
        end
        casLowRun++;
        if (dramRasN) modeErr++;
        if (prevCas && (dramWeN != prevWe)) modeErr++;
        if (!dramWeN && (!dramOeN || !dramDqOe)) modeErr++;
        if (dramWeN && (dramOeN || dramDqOe)) modeErr++;
      end else begin
        if (prevCas) begin
          if (casLowRun < minCasLow) minCasLow = casLowRun;
          casHighRun = 0;
        end
        casHighRun++;
      end
      if (rdValid) rdPulses++;
      prevRas = dramRasN; prevCas = casLo; prevWe = dramWeN;
    end
  end

  int nReads = 0;

  task automatic issue(input bit wr, input logic [17:0] a, input logic [1:0] be,
                       input logic [15:0] wd);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqByteEn = be; reqWdata = wd;
    #1;
    while (!reqReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    if (!wr) nReads++;
  endtask

  task automatic readWord(input logic [17:0] a, input logic [1:0] be,
                          output logic [15:0] d);
    issue(0, a, be, 16'h0);
    d = 16'hxxxx;
    for (int i = 0; i < 40; i++) begin
      if (rdValid) begin
        d = rdData;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic waitQuiet();
    repeat (12) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 strobes", {dramRasN, dramLcasN, dramUcasN, dramWeN, dramOeN}, 5'b11111);
    check("R1 outputs", {dramDqOe, rdValid, refGnt, reqReady}, 4'b0000);
    rstN = 1;
    @(negedge clk);
    check("R1 after release", {dramRasN, dramLcasN, dramUcasN, dramWeN, dramOeN, dramDqOe, rdValid}, 7'b1111100);
  endtask

  task automatic testWriteRead();
    logic [15:0] d;
    issue(1, mk(3, 5), 2'b11, 16'h1234);
    waitQuiet();
    check("R2 row latched at RAS fall", int'(rowL), 3);
    check("R2 column latched at CAS fall", int'(colL), 5);
    check("R4 early write stored", int'(mem[{5'd3, 5'd5}]), 16'h1234);
    check("R8 RAS-to-CAS delay", lastRcd, T_RCD + 1);
    readWord(mk(3, 5), 2'b11, d);
    check("R5 word read data", int'(d), 16'h1234);
  endtask

  task automatic testPageHit();
    logic [15:0] d;
    int f0;
    f0 = rasFalls;
    readWord(mk(3, 6), 2'b11, d);
    check("R6 hit read data", int'(d), int'(pat(3 * 32 + 6)));
    check("R6 no new row open", rasFalls, f0);
  endtask

  task automatic testBytes();
    logic [15:0] d;
    int u0, l0;
    u0 = uFalls;
    issue(1, mk(3, 5), 2'b01, 16'hABCD);
    waitQuiet();
    check("R3 lower write keeps upper strobe high", uFalls, u0);
    issue(1, mk(3, 5), 2'b10, 16'h5600);
    waitQuiet();
    readWord(mk(3, 5), 2'b11, d);
    check("R3 merged bytes", int'(d), 16'h56CD);
    l0 = lFalls;
    readWord(mk(3, 5), 2'b10, d);
    check("R3 upper byte read", int'(d[15:8]), 16'h56);
    check("R3 upper read keeps lower strobe high", lFalls, l0);
  endtask

  task automatic testRowMiss();
    logic [15:0] d;
    int f0;
    f0 = rasFalls;
    readWord(mk(7, 1), 2'b11, d);
    check("R7 miss read data", int'(d), int'(pat(7 * 32 + 1)));
    check("R7 row reopened", rasFalls, f0 + 1);
    checkTrue("R7 precharge width", minPre >= T_RP, minPre, T_RP);
    checkTrue("R8 RAS low width", minRasLow >= RAS_MIN, minRasLow, RAS_MIN);
  endtask

  task automatic testRefresh();
    logic [15:0] d;
    int waited, readyCnt, f0;
    @(negedge clk);
    refReq = 1;
    waited = 0;
    while (!refGnt && waited < 60) begin
      @(negedge clk);
      waited++;
    end
    check("R10 grant given", int'(refGnt), 1);
    check("R10 row closed at grant", int'(dramRasN), 1);
    checkTrue("R10 precharged before grant", rasHighRun >= T_RP, rasHighRun, T_RP);
    reqValid = 1; reqWrite = 0; reqAddr = mk(7, 2); reqByteEn = 2'b11;
    readyCnt = 0;
    for (int i = 0; i < 6; i++) begin
      #1;
      if (reqReady) readyCnt++;
      @(negedge clk);
    end
    reqValid = 0;
    check("R10 nothing accepted in grant", readyCnt, 0);
    refReq = 0;
    @(negedge clk);
    check("R10 grant released", int'(refGnt), 0);
    f0 = rasFalls;
    minPre = 1000;
    readWord(mk(7, 2), 2'b11, d);
    check("R10 access after refresh", int'(d), int'(pat(7 * 32 + 2)));
    checkTrue("R10 precharge after release", minPre >= T_RP, minPre, T_RP);
    check("R10 row opened once", rasFalls, f0 + 1);
  endtask

  task automatic testPageLimit();
    logic [15:0] d;
    int f0, bad;
    f0 = rasFalls; bad = 0; maxRasLow = 0;
    for (int i = 0; i < 30; i++) begin
      readWord(mk(2, i), 2'b11, d);
      if (d != pat(2 * 32 + i)) bad++;
    end
    waitQuiet();
    check("R9 data under forced closes", bad, 0);
    checkTrue("R9 RAS low run bound", maxRasLow <= LIMIT, maxRasLow, LIMIT);
    checkTrue("R9 row closed and reopened", rasFalls >= f0 + 2, rasFalls - f0, 2);
  endtask

  task automatic testTotals();
    waitQuiet();
    check("R11 one pulse per read", rdPulses, nReads);
    check("R4 R5 strobe mode errors", modeErr, 0);
    checkTrue("R8 CAS low width", minCasLow >= CAS_MIN, minCasLow, CAS_MIN);
    checkTrue("R8 CAS high in page", minCasHigh >= 1, minCasHigh, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testWriteRead();
    testPageHit();
    testBytes();
    testRowMiss();
    testRefresh();
    testPageLimit();
    testTotals();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule